// File: doc/BRIEF.md
# Strobe-Kicked Processor Watchdog

This block watches a processor for signs of life. A free-running count advances once per timebase tick, and the monitored software must keep restarting it by driving a high-to-low transition on its strobe line. If the count reaches the selected period first, the block emits a one-clock timeout pulse. A reset controller downstream turns that pulse into a stretched system reset.

A 2-bit select chooses one of three periods: short, medium or long. With a 1 ms tick these are nominally 150, 610 and 1200 ticks. The raw strobe is asynchronous. It passes through a two-flop synchronizer and a third history flop, and only a falling edge seen there restarts the count. While the reset controller reports an active system reset, the count is held at zero and strobes are disregarded. No input exists that stops the watchdog once reset is gone.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst` is high, `timeout_pulse` is low, and after release the count starts from zero.
- R2: Select 2'b00, 2'b01 and 2'b10 give periods of P_SHORT, P_MID and P_LONG ticks. `timeout_pulse` is high in the clock after the tick that completes the period, counted from the last clear.
- R3: Select 2'b11 behaves exactly like 2'b10.
- R4: A falling edge on `strobe_n` restarts the count, even when it is low for only one clock. The raw low level is sampled at clock edge k, and the count is cleared at edge k+2.
- R5: A strobe held steady (high or low), or a rising edge, does not restart the count.
- R6: While `sys_rst_active` is high, the count is held at zero, no pulse is produced and strobes have no effect.
- R7: Each timeout pulse lasts one clock and restarts the count, so pulses repeat every period while no strobe arrives. The watchdog cannot be disabled.
- R8: The count advances only in cycles where `tick` is high. No pulse is produced in the clock after a cycle without a tick.
- R9: If the select is changed to a period that is already used up, the pulse fires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase enable, one clock wide |
| period_sel | input | 2 | Period select: 00 short, 01 medium, 10/11 long |
| strobe_n | input | 1 | Raw asynchronous strobe; falling edge restarts the count |
| sys_rst_active | input | 1 | High while a system reset is being held |
| timeout_pulse | output | 1 | One-clock timeout request |

## Verification
The hardest situation to reach from the ports is a select change that lands on a count already past the new period. This requires a long period to be partly used before the select drops. A directed sequence clears the block, runs eight ticks on the long period and then switches to the short one in a tick cycle. One-clock strobe lows are placed at set distances so that they fall just inside a period. A long random phase then mixes sparse ticks, strobe toggles, select changes and short system resets. It is checked cycle by cycle against a bench model that counts ticks since the last clear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_ALIAS = 2'b11
  } wdg_sel_e;

  // Number of ticks in the selected period; 2'b11 aliases the long period.
  function automatic int wdg_period(input logic [1:0] sel, input int p_s, input int p_m, input int p_l);
    case (wdg_sel_e'(sel))
      SEL_SHORT: return p_s;
      SEL_MID:   return p_m;
      default:   return p_l;
    endcase
  endfunction

  // Count value at which the next tick completes the period.
  function automatic int wdg_last_idx(input logic [1:0] sel, input int p_s, input int p_m, input int p_l);
    return wdg_period(sel, p_s, p_m, p_l) - 1;
  endfunction

  function automatic int wdg_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous synced sample.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] last_idx,
  output logic          expire,
  output logic [CW-1:0] count
);
  logic reach, fire;

  assign reach = (count >= last_idx);
  assign fire  = tick & ~clear & reach;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= fire;
      if (clear | fire) count <= '0;
      else if (tick)    count <= count + 1'b1;
    end
  end

  a_r8_no_tick_no_expire: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !expire);
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
  a_r7_restart_after_expire: assert property (@(posedge clk) disable iff (rst)
    expire |-> (count == '0));
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int P_SHORT = 150,
  parameter int P_MID   = 610,
  parameter int P_LONG  = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] period_sel,
  input  logic       strobe_n,
  input  logic       sys_rst_active,
  output logic       timeout_pulse
);
  import wdg_pkg::*;

  localparam int PMAX = wdg_max3(P_SHORT, P_MID, P_LONG);
  localparam int CW   = $clog2(PMAX + 1);

  logic          strobe_fall;
  logic          kick;
  logic          hold_clear;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] count;

  wdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (strobe_n),
    .fall (strobe_fall)
  );

  assign kick       = strobe_fall & ~sys_rst_active;
  assign hold_clear = sys_rst_active | kick;
  assign last_idx   = CW'(wdg_last_idx(period_sel, P_SHORT, P_MID, P_LONG));

  wdg_tick_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (hold_clear),
    .tick     (tick),
    .last_idx (last_idx),
    .expire   (timeout_pulse),
    .count    (count)
  );

  a_r6_sysrst_quiet: assert property (@(posedge clk) disable iff (rst)
    sys_rst_active |=> (!timeout_pulse && count == '0));
  a_r4_kick_clears: assert property (@(posedge clk) disable iff (rst)
    kick |=> (count == '0 && !timeout_pulse));
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
    count < CW'(PMAX));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0 && !timeout_pulse));
endmodule

// File: tb/strobe_watchdog_test.sv
`timescale 1ns/1ps
module strobe_watchdog_test;
  localparam int PS = 4, PM = 7, PL = 11;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, strobe_n = 1'b1, sys_rst_active = 1'b0;
  logic [1:0] period_sel = 2'b00;
  logic timeout_pulse;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;
  // bench model state
  bit m1 = 1, m2 = 1, m3 = 1;
  int ticks_since_clear = 0;
  bit last_exp = 0;

  always #5 clk = ~clk;

  strobe_watchdog #(.P_SHORT(PS), .P_MID(PM), .P_LONG(PL)) uut (
    .clk(clk), .rst(rst), .tick(tick), .period_sel(period_sel),
    .strobe_n(strobe_n), .sys_rst_active(sys_rst_active),
    .timeout_pulse(timeout_pulse)
  );

  function automatic int bench_period(input logic [1:0] s);
    if (s == 2'b00) return PS;
    if (s == 2'b01) return PM;
    return PL; // 10 and 11 alike
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: timeout_pulse=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: predict, advance, compare away from the edge
  task automatic cyc(input string tag);
    bit edge_seen, live, fire;
    edge_seen = m3 && !m2;
    live = !rst && !sys_rst_active;
    fire = live && !edge_seen && tick && (ticks_since_clear + 1 >= bench_period(period_sel));
    if (rst || sys_rst_active || edge_seen || fire) ticks_since_clear = 0;
    else if (tick) ticks_since_clear++;
    if (rst) begin m1 = 1; m2 = 1; m3 = 1; end
    else begin m3 = m2; m2 = m1; m1 = strobe_n; end
    @(posedge clk); @(negedge clk);
    last_exp = fire;
    if (timeout_pulse) pulses++;
    check(tag, timeout_pulse, fire);
  endtask

  task automatic clear_wd();
    sys_rst_active = 1; tick = 1;
    repeat (3) cyc("R6");
    sys_rst_active = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1832);
    @(negedge clk);
    // R1: reset state
    rst = 1; tick = 1;
    repeat (3) cyc("R1");
    rst = 0;

    // R2 / R7: each period fires twice in 2p+1 ticks
    for (int s = 0; s < 3; s++) begin
      period_sel = 2'(s);
      clear_wd();
      pulses = 0;
      tick = 1;
      repeat (2 * bench_period(period_sel) + 1) cyc("R2");
      checks++;
      if (pulses != 2) begin failures++; $display("FAIL R7: pulses=%0d expected=2", pulses); end
    end

    // R3: 11 aliases 10 -- first pulse exactly PL ticks after clear
    period_sel = 2'b11;
    clear_wd();
    tick = 1; pulses = 0;
    repeat (PL - 1) cyc("R3");
    checks++;
    if (pulses != 0) begin failures++; $display("FAIL R3: pulses=%0d expected=0", pulses); end
    cyc("R3");
    check("R3 alias pulse", timeout_pulse, 1'b1);

    // R4: one-clock low strobes every 8 clocks keep long period alive
    period_sel = 2'b10;
    clear_wd();
    tick = 1; pulses = 0;
    for (int i = 0; i < 80; i++) begin
      strobe_n = (i % 8 == 4) ? 1'b0 : 1'b1;
      cyc("R4");
    end
    strobe_n = 1;
    checks++;
    if (pulses != 0) begin failures++; $display("FAIL R4: pulses=%0d expected=0", pulses); end

    // R5: steady low, then a rising edge, do not restart
    strobe_n = 0;
    repeat (4) cyc("R5");
    clear_wd();
    tick = 1; pulses = 0;
    repeat (2) cyc("R5");
    strobe_n = 1;
    repeat (PL - 2) cyc("R5");
    check("R5 rising edge ignored", timeout_pulse, 1'b1);

    // R6: strobes toggling during system reset, long hold
    sys_rst_active = 1; pulses = 0;
    for (int i = 0; i < 40; i++) begin
      strobe_n = i[2];
      cyc("R6");
    end
    strobe_n = 1;
    repeat (3) cyc("R6");
    sys_rst_active = 0;
    checks++;
    if (pulses != 0) begin failures++; $display("FAIL R6: pulses=%0d expected=0", pulses); end

    // R8: no ticks, no pulse
    period_sel = 2'b00;
    clear_wd();
    tick = 0; pulses = 0;
    repeat (30) cyc("R8");
    checks++;
    if (pulses != 0) begin failures++; $display("FAIL R8: pulses=%0d expected=0", pulses); end

    // R9: long period partly used, then select drops to short
    period_sel = 2'b10;
    clear_wd();
    tick = 1;
    repeat (8) cyc("R9");
    period_sel = 2'b00;
    cyc("R9");
    check("R9 shrink fires", timeout_pulse, 1'b1);

    // random mix checked against the model every clock
    for (int i = 0; i < 3000; i++) begin
      tick = ($urandom % 3) == 0;
      if (($urandom % 5) == 0) strobe_n = ~strobe_n;
      if (($urandom % 60) == 0) period_sel = 2'($urandom);
      sys_rst_active = ($urandom % 50) == 0;
      cyc("R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule